// File: doc/BRIEF.md
# Interrupting General-Purpose Pin Controller

This block manages thirty-two general-purpose pins from a plain 32-bit register port. Each pin is either an output, driven from a stored data word, or an input. Inputs pass through a synchroniser, and the synchronised level can be read back. Every input pin can raise an interrupt. A pin chooses between a low or high level condition and a rising or falling edge condition. A per-pin "both edges" bit overrides that choice.

Events are held in sticky status bits, which software clears by writing ones. The status is ANDed with an enable mask and reduced onto the interrupt lines. A parameter selects the split form, with one line for pins 0-15 and one for pins 16-31, or a single combined line. A second parameter removes the both-edges register entirely.

The register map uses byte offsets. Offset 0x00 is the data word, 0x04 the direction, and 0x08 the sampled pad levels. Offsets 0x0C and 0x10 hold the lower and upper halves of the trigger-mode field. Offset 0x14 is the enable mask, 0x18 the status, and 0x1C the both-edges select. Every other offset, including any offset that is not a multiple of four, is unmapped.

Top module: `gpio_ctrl`

## Requirements
- R1: A pin whose direction bit is 1 (output) never sets its status bit, whatever its pad does. Switching a pin back to input does not count the level it already had as an edge.
- R2: With trigger mode 00 a pin flags in every cycle that its sampled level is 0. With mode 01 it flags in every cycle that the level is 1. A bit cleared while the condition still holds is set again.
- R3: Mode 10 flags only a 0-to-1 change of the sampled level, and mode 11 flags only a 1-to-0 change. Each change is measured against the level sampled one cycle earlier.
- R4: A pin with its both-edges bit set flags every change of its sampled level in either direction, and ignores its 2-bit mode, including the level modes.
- R5: Pin p takes its mode from bits 2p+1:2p of the 64-bit value {upper mode register at 0x10, lower mode register at 0x0C}. Pin 20 therefore uses bits 9:8 of the register at 0x10.
- R6: A read of the data word at 0x00 returns the stored data bit for each output pin and the sampled pad level for each input pin.
- R7: A read of the pad register at 0x08 returns the sampled level for each input pin and 0 for each output pin.
- R8: With the split option, irq[0] is the OR of (status AND mask) over bits 15:0 and irq[1] the OR over bits 31:16. Without it, irq[0] covers all 32 bits and irq[1] stays 0.
- R9: Writing a 1 to a status bit clears it and writing 0 leaves it unchanged. When a clear and a new event reach the same bit on the same clock edge, the bit stays set.
- R10: pad_out and pad_oe show the data and direction registers from the clock edge that accepts the write.
- R11: With the both-edges option absent, offset 0x1C reads 0, and writes to it change neither the readback nor the detection.
- R12: All registers reset to 0. Unmapped offsets read 0, and writes to them change no register.
- R13: A pad change reaches the status register on the third rising clock edge after it is applied, two edges for the synchroniser and one for the status flop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, combinational from the address; 0 when no read is requested |
| pad_in | input | NUM_PINS | Raw, asynchronous pad levels |
| pad_out | output | NUM_PINS | Levels driven by the pins |
| pad_oe | output | NUM_PINS | Per-pin output enable (1 = output) |
| irq | output | 2 | Interrupt lines; bit 1 is used only with the split option |

## Verification
Two things can hit the same status bit on the same clock edge: a software clear and a freshly detected event. The bench first measures the latency of R13. It then raises an input so that its rising edge is detected on the same edge that accepts a write-one-to-clear of that bit. The bit must still read 1 afterwards, and a later clear that has no event beside it must bring the bit to 0. A level-mode pin cleared while its condition still holds is judged the same way, since it must read as set again.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

   // byte offsets of the register file
   localparam logic [7:0] OFS_DATA    = 8'h00;
   localparam logic [7:0] OFS_DIR     = 8'h04;
   localparam logic [7:0] OFS_PAD     = 8'h08;
   localparam logic [7:0] OFS_MODE_LO = 8'h0C;
   localparam logic [7:0] OFS_MODE_HI = 8'h10;
   localparam logic [7:0] OFS_MASK    = 8'h14;
   localparam logic [7:0] OFS_STATUS  = 8'h18;
   localparam logic [7:0] OFS_ANYEDGE = 8'h1C;

   // trigger mode encoding; bit 1 selects edge, bit 0 the polarity
   typedef enum logic [1:0] {
      TRIG_LOW  = 2'b00,
      TRIG_HIGH = 2'b01,
      TRIG_RISE = 2'b10,
      TRIG_FALL = 2'b11
   } trig_mode_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
   import gpio_pkg::*;
(
   input  logic       lvl,
   input  logic       prev,
   input  logic       is_output,
   input  logic [1:0] mode,
   input  logic       any_edge,
   output logic       hit
);

   logic changed;
   assign changed = lvl ^ prev;

   always_comb begin
      if (is_output)
         hit = 1'b0;
      else if (any_edge)
         hit = changed;
      else if (mode == TRIG_RISE || mode == TRIG_FALL)
         hit = changed & (lvl ^ mode[0]);
      else
         hit = ~(lvl ^ mode[0]);
   end

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
   parameter int NUM_PINS  = 32,
   parameter bit SPLIT_IRQ = 1
) (
   input  logic [NUM_PINS-1:0] pending,
   output logic [1:0]          irq
);

   localparam int HALF = NUM_PINS / 2;

   generate
      if (SPLIT_IRQ) begin : g_split
         assign irq = {|pending[NUM_PINS-1:HALF], |pending[HALF-1:0]};
      end else begin : g_single
         assign irq = {1'b0, |pending};
      end
   endgenerate

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
   import gpio_pkg::*;
#(
   parameter int NUM_PINS     = 32,
   parameter int BUS_W        = 32,
   parameter int ADDR_W       = 6,
   parameter int SYNC_STAGES  = 2,
   parameter bit HAS_ANY_EDGE = 1,
   parameter bit SPLIT_IRQ    = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_valid,
   input  logic                bus_write,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [BUS_W-1:0]    bus_wdata,
   output logic [BUS_W-1:0]    bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [1:0]          irq
);

   localparam int MODE_W = 2 * NUM_PINS;

   generate
      if (NUM_PINS != 32 || BUS_W != 32) begin : g_bad_width
         $error("gpio_ctrl: the register layout needs NUM_PINS == BUS_W == 32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_ctrl: SYNC_STAGES must be at least 2");
      end
      if (ADDR_W < 5 || ADDR_W > 8) begin : g_bad_addr
         $error("gpio_ctrl: ADDR_W must lie in 5..8");
      end
   endgenerate

   logic [NUM_PINS-1:0] data_q, dir_q, mask_q, status_q, anyedge_q;
   logic [MODE_W-1:0]   mode_q;
   logic [NUM_PINS-1:0] lvl, lvl_prev_q, hit, clr;
   logic                wr, rd;
   logic                sel_data, sel_dir, sel_pad, sel_mlo, sel_mhi;
   logic                sel_mask, sel_status, sel_any;

   assign wr = bus_valid & bus_write;
   assign rd = bus_valid & ~bus_write;

   assign sel_data   = bus_addr == ADDR_W'(OFS_DATA);
   assign sel_dir    = bus_addr == ADDR_W'(OFS_DIR);
   assign sel_pad    = bus_addr == ADDR_W'(OFS_PAD);
   assign sel_mlo    = bus_addr == ADDR_W'(OFS_MODE_LO);
   assign sel_mhi    = bus_addr == ADDR_W'(OFS_MODE_HI);
   assign sel_mask   = bus_addr == ADDR_W'(OFS_MASK);
   assign sel_status = bus_addr == ADDR_W'(OFS_STATUS);
   assign sel_any    = bus_addr == ADDR_W'(OFS_ANYEDGE);

   gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (lvl)
   );

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         gpio_pin_detect u_det (
            .lvl       (lvl[p]),
            .prev      (lvl_prev_q[p]),
            .is_output (dir_q[p]),
            .mode      (mode_q[2*p +: 2]),
            .any_edge  (anyedge_q[p]),
            .hit       (hit[p])
         );
      end

      if (HAS_ANY_EDGE) begin : g_any
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              anyedge_q <= '0;
            else if (wr && sel_any)  anyedge_q <= bus_wdata;
         end
      end else begin : g_no_any
         assign anyedge_q = '0;
      end
   endgenerate

   assign clr = (wr && sel_status) ? bus_wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q     <= '0;
         dir_q      <= '0;
         mask_q     <= '0;
         mode_q     <= '0;
         status_q   <= '0;
         lvl_prev_q <= '0;
      end else begin
         if (wr && sel_data) data_q <= bus_wdata;
         if (wr && sel_dir)  dir_q  <= bus_wdata;
         if (wr && sel_mask) mask_q <= bus_wdata;
         if (wr && sel_mlo)  mode_q[MODE_W/2-1:0]      <= bus_wdata;
         if (wr && sel_mhi)  mode_q[MODE_W-1:MODE_W/2] <= bus_wdata;
         // a new event outranks a clear of the same bit
         status_q   <= (status_q & ~clr) | hit;
         lvl_prev_q <= lvl;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (rd) begin
         if (sel_data)        bus_rdata = (data_q & dir_q) | (lvl & ~dir_q);
         else if (sel_dir)    bus_rdata = dir_q;
         else if (sel_pad)    bus_rdata = lvl & ~dir_q;
         else if (sel_mlo)    bus_rdata = mode_q[MODE_W/2-1:0];
         else if (sel_mhi)    bus_rdata = mode_q[MODE_W-1:MODE_W/2];
         else if (sel_mask)   bus_rdata = mask_q;
         else if (sel_status) bus_rdata = status_q;
         else if (sel_any)    bus_rdata = anyedge_q;
      end
   end

   assign pad_out = data_q;
   assign pad_oe  = dir_q;

   gpio_irq_merge #(.NUM_PINS(NUM_PINS), .SPLIT_IRQ(SPLIT_IRQ)) u_irq (
      .pending (status_q & mask_q),
      .irq     (irq)
   );

endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
   import gpio_pkg::*;
#(
   parameter int NUM_PINS     = 32,
   parameter int BUS_W        = 32,
   parameter int ADDR_W       = 6,
   parameter bit HAS_ANY_EDGE = 1,
   parameter bit SPLIT_IRQ    = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_valid,
   input logic                bus_write,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [BUS_W-1:0]    bus_wdata,
   input logic [BUS_W-1:0]    bus_rdata,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [1:0]          irq,
   input logic [NUM_PINS-1:0] status,
   input logic [NUM_PINS-1:0] mask,
   input logic [NUM_PINS-1:0] dir
);

   localparam int HALF = NUM_PINS / 2;

   logic [NUM_PINS-1:0] clr_req;
   always_comb
      clr_req = (bus_valid && bus_write && bus_addr == ADDR_W'(OFS_STATUS)) ? bus_wdata : '0;

   p_dir_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ((status & ~$past(status)) & $past(dir)) == '0);

   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(status) & ~status) & ~$past(clr_req)) == '0);

   p_dout_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && bus_addr == ADDR_W'(OFS_DATA)) |=> (pad_out == $past(bus_wdata)));

   p_unmapped_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write &&
       (bus_addr > ADDR_W'(OFS_ANYEDGE) || bus_addr[1:0] != 2'b00)) |-> bus_rdata == '0);

   generate
      if (SPLIT_IRQ) begin : g_split_chk
         p_irq_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
            irq[0] |-> |(status[HALF-1:0] & mask[HALF-1:0]));
         p_irq_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
            irq[1] |-> |(status[NUM_PINS-1:HALF] & mask[NUM_PINS-1:HALF]));
      end else begin : g_single_chk
         p_irq_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
            irq[0] |-> |(status & mask));
         p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
            |(status & mask) |-> irq == 2'b01);
      end
      if (!HAS_ANY_EDGE) begin : g_noany_chk
         p_noany_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && !bus_write && bus_addr == ADDR_W'(OFS_ANYEDGE)) |-> bus_rdata == '0);
      end
   endgenerate

endmodule

bind gpio_ctrl gpio_ctrl_chk #(
   .NUM_PINS     (NUM_PINS),
   .BUS_W        (BUS_W),
   .ADDR_W       (ADDR_W),
   .HAS_ANY_EDGE (HAS_ANY_EDGE),
   .SPLIT_IRQ    (SPLIT_IRQ)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_valid (bus_valid),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_out   (pad_out),
   .irq       (irq),
   .status    (status_q),
   .mask      (mask_q),
   .dir       (dir_q)
);

// File: tb/sim_gpio_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_ctrl;

   localparam logic [5:0] A_DATA = 6'h00, A_DIR = 6'h04, A_PAD = 6'h08,
                          A_MLO = 6'h0C, A_MHI = 6'h10, A_MASK = 6'h14,
                          A_STAT = 6'h18, A_ANY = 6'h1C, A_HOLE = 6'h20,
                          A_ODD = 6'h05;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] pad_in = '0;
   logic [31:0] rdata0, rdata1, pad_out0, pad_out1, pad_oe0, pad_oe1;
   logic [1:0]  irq0, irq1;
   logic [31:0] pad = '0;
   int          n_cmp = 0, n_bad = 0;

   always #10 clk = ~clk;

   gpio_ctrl #(.HAS_ANY_EDGE(1), .SPLIT_IRQ(1)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata0),
      .pad_in(pad_in), .pad_out(pad_out0), .pad_oe(pad_oe0), .irq(irq0));

   gpio_ctrl #(.HAS_ANY_EDGE(0), .SPLIT_IRQ(0)) u1 (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata1),
      .pad_in(pad_in), .pad_out(pad_out1), .pad_oe(pad_oe1), .irq(irq1));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1 bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic bus_rd(input logic [5:0] a, output logic [31:0] d0, output logic [31:0] d1);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      #2 d0 = rdata0; d1 = rdata1;
      bus_valid = 1'b0;
   endtask

   task automatic drive_pad();
      @(negedge clk);
      pad_in = pad;
   endtask

   task automatic settle();
      repeat (4) @(posedge clk);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // R12: every register reads 0 while reset is held
   task automatic t_reset();
      logic [31:0] a, b;
      for (int i = 0; i < 9; i++) begin
         bus_rd(6'(i * 4), a, b);
         chk($sformatf("R12 reset read offset %0h", i * 4), a, 32'h0);
      end
      chk("R12 reset irq", {30'h0, irq0}, 32'h0);
      chk("R12 reset pad_oe", pad_oe0, 32'h0);
      chk("R12 reset pad_out", pad_out0, 32'h0);
   endtask

   task automatic setup_rise();
      logic [31:0] a, b;
      bus_wr(A_MLO, 32'hAAAA_AAAA);
      bus_wr(A_MHI, 32'hAAAA_AAAA);
      bus_wr(A_STAT, 32'hFFFF_FFFF);
      settle();
      bus_rd(A_STAT, a, b);
      chk("R9 write-one clears all status", a, 32'h0);
   endtask

   // R3 / R13: rising detection and its latency
   task automatic t_rising();
      logic [31:0] a, b;
      pad[3] = 1'b1; drive_pad();
      repeat (2) @(posedge clk);
      bus_rd(A_STAT, a, b);
      chk("R13 status still clear after two edges", a, 32'h0);
      @(posedge clk);
      bus_rd(A_STAT, a, b);
      chk("R13 R3 rising flagged on third edge", a, 32'h8);
      bus_wr(A_STAT, 32'h8);
      pad[3] = 1'b0; drive_pad(); settle();
      bus_rd(A_STAT, a, b);
      chk("R3 rising mode ignores falling", a, 32'h0);
   endtask

   // R9: clear and event on the same edge
   task automatic t_clear_race();
      logic [31:0] a, b;
      pad[3] = 1'b1; drive_pad(); settle();
      pad[3] = 1'b0; drive_pad(); settle();
      bus_rd(A_STAT, a, b);
      chk("R9 bit3 pending before race", a, 32'h8);
      pad[3] = 1'b1; drive_pad();
      repeat (2) @(posedge clk);
      bus_wr(A_STAT, 32'h8);
      bus_rd(A_STAT, a, b);
      chk("R9 set wins over same-edge clear", a, 32'h8);
      bus_wr(A_STAT, 32'h8);
      bus_rd(A_STAT, a, b);
      chk("R9 lone clear takes effect", a, 32'h0);
   endtask

   // R5 / R3: pin 20 falling via bits 9:8 of the upper mode register
   task automatic t_falling();
      logic [31:0] a, b;
      bus_wr(A_MHI, 32'hAAAA_ABAA);
      pad[20] = 1'b1; drive_pad(); settle();
      bus_rd(A_STAT, a, b);
      chk("R5 pin20 falling mode ignores rise", a, 32'h0);
      pad[20] = 1'b0; drive_pad(); settle();
      bus_rd(A_STAT, a, b);
      chk("R3 R5 pin20 falling flagged", a, 32'h0010_0000);
      bus_wr(A_STAT, 32'hFFFF_FFFF);
      bus_wr(A_MHI, 32'hAAAA_AAAA);
   endtask

   // R2: level modes re-assert after a clear
   task automatic t_level();
      logic [31:0] a, b;
      bus_wr(A_MLO, 32'hAAAA_86AA);
      settle();
      bus_rd(A_STAT, a, b);
      chk("R2 pin6 low-level flags", a, 32'h40);
      pad[5] = 1'b1; drive_pad(); settle();
      bus_rd(A_STAT, a, b);
      chk("R2 pin5 high-level flags", a, 32'h60);
      bus_wr(A_STAT, 32'h60); settle();
      bus_rd(A_STAT, a, b);
      chk("R2 level condition sets again after clear", a, 32'h60);
      bus_wr(A_MLO, 32'hAAAA_AAAA);
      bus_wr(A_STAT, 32'hFFFF_FFFF); settle();
      bus_rd(A_STAT, a, b);
      chk("R2 status quiet once level modes leave", a, 32'h0);
   endtask

   // R4 / R11: both-edges override, and its absence in u1
   task automatic t_anyedge();
      logic [31:0] a, b;
      bus_wr(A_MLO, 32'hAAAA_6AAA);
      bus_wr(A_ANY, 32'h80);
      bus_rd(A_ANY, a, b);
      chk("R4 both-edges register readback", a, 32'h80);
      chk("R11 absent both-edges reads 0", b, 32'h0);
      pad[7] = 1'b1; drive_pad(); settle();
      bus_rd(A_STAT, a, b);
      chk("R4 both-edges flags rise", a, 32'h80);
      bus_wr(A_STAT, 32'h80); settle();
      bus_rd(A_STAT, a, b);
      chk("R4 both-edges overrides level mode", a, 32'h0);
      chk("R11 absent register leaves level mode active", b, 32'h80);
      pad[7] = 1'b0; drive_pad(); settle();
      bus_rd(A_STAT, a, b);
      chk("R4 both-edges flags fall", a, 32'h80);
      bus_wr(A_ANY, 32'h0);
      bus_wr(A_MLO, 32'hAAAA_AAAA);
      bus_wr(A_STAT, 32'hFFFF_FFFF); settle();
      bus_rd(A_STAT, a, b);
      chk("R11 u1 status clear after restore", b, 32'h0);
   endtask

   // R1 / R6 / R7 / R10: direction, readback and drive
   task automatic t_dir();
      logic [31:0] a, b;
      bus_wr(A_DIR, 32'h0000_FF00);
      bus_wr(A_DATA, 32'h1234_5678);
      chk("R10 pad_out follows data", pad_out0, 32'h1234_5678);
      chk("R10 pad_oe follows direction", pad_oe0, 32'h0000_FF00);
      pad[8] = 1'b1; drive_pad(); settle();
      bus_rd(A_STAT, a, b);
      chk("R1 output pin edge ignored", a, 32'h0);
      bus_rd(A_DATA, a, b);
      chk("R6 data readback mixes", a, (32'h1234_5678 & 32'h0000_FF00) | (pad & ~32'h0000_FF00));
      bus_rd(A_PAD, a, b);
      chk("R7 pad read hides outputs", a, pad & ~32'h0000_FF00);
      bus_wr(A_DIR, 32'h0); settle();
      bus_rd(A_STAT, a, b);
      chk("R1 turning input is no edge", a, 32'h0);
      pad[8] = 1'b0; drive_pad(); settle();
   endtask

   // R8: split and combined interrupt lines
   task automatic t_irq();
      pad[2] = 1'b1; drive_pad(); settle();
      @(negedge clk);
      chk("R8 masked-off status gives no irq", {28'h0, irq1, irq0}, 32'h0);
      bus_wr(A_MASK, 32'h0010_0004);
      @(negedge clk);
      chk("R8 split low line", {30'h0, irq0}, 32'h1);
      chk("R8 combined line", {30'h0, irq1}, 32'h1);
      pad[20] = 1'b1; drive_pad(); settle();
      @(negedge clk);
      chk("R8 split both lines", {30'h0, irq0}, 32'h3);
      bus_wr(A_STAT, 32'h4);
      @(negedge clk);
      chk("R8 split high line only", {30'h0, irq0}, 32'h2);
      chk("R8 combined covers upper pins", {30'h0, irq1}, 32'h1);
      bus_wr(A_STAT, 32'hFFFF_FFFF);
      @(negedge clk);
      chk("R8 irq drops after clear", {28'h0, irq1, irq0}, 32'h0);
   endtask

   // R12: unmapped offsets
   task automatic t_unmapped();
      logic [31:0] a, b;
      bus_wr(A_HOLE, 32'hFFFF_FFFF);
      bus_wr(A_ODD, 32'hFFFF_FFFF);
      bus_rd(A_HOLE, a, b);
      chk("R12 unmapped reads 0", a, 32'h0);
      bus_rd(A_ODD, a, b);
      chk("R12 misaligned reads 0", a, 32'h0);
      chk("R12 data kept after unmapped write", pad_out0, 32'h1234_5678);
      bus_rd(A_DIR, a, b);
      chk("R12 direction kept", a, 32'h0);
      bus_rd(A_MASK, a, b);
      chk("R12 mask kept", a, 32'h0010_0004);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      setup_rise();
      t_rising();
      t_clear_race();
      t_falling();
      t_level();
      t_anyedge();
      t_dir();
      t_irq();
      t_unmapped();
      finish_run();
   end

endmodule